// File: doc/BRIEF.md
# Dual DAC Command Decoder and Registers

This block sits behind a serial receiver. It takes each completed 16-bit command word and keeps the digital state of a two-channel voltage DAC. Each channel is double-buffered. A staging (input) register can be written without disturbing the converter. A DAC register holds the code that is actually being converted. Commands can load staging registers, move staged codes into the DAC registers, or load both levels at once.

The same command stream also does the following:

- it shuts channels down one at a time or together;
- it drives a general-purpose logic output;
- it selects the edge mode that the serial-output shifter uses.

A lockout input guards shutdown. While the lockout input is low, shutdown requests are refused, and the falling edge of the input wakes both channels at once. An active-low clear zeroes the code registers. A synchronous active-low reset returns everything to its power-up state.

Top module: `dual_dac_ctrl`

## Requirements

The command word carries a 3-bit opcode in bits 15:13 and 13 data bits in bits 12:0. Channel A is index 0 and channel B is index 1.

- R1: Opcode 001 loads the data into staging A, and opcode 101 loads it into staging B. Neither changes a DAC register.
- R2: Opcode 010 loads staging A, and opcode 110 loads staging B. In the same command, both DAC registers take their staging values, and the channel just written takes the new data.
- R3: Opcode 011 writes the data into both staging registers and both DAC registers.
- R4: Opcode 100 copies each staging register into its own DAC register.
- R5: Shutdown requests take effect only while pd_allow is high:
  - opcode 111 shuts down both channels;
  - with opcode 000, sub-code (bits 12:9) 110x shuts down A and 111x shuts down B.
- R6: With opcode 000, sub-code 001x copies staging A into DAC A, and 101x copies staging B into DAC B. The other channel is untouched.
- R7: With opcode 000, sub-code 010x drives gpo low and 011x drives it high. gpo is low after reset.
- R8: With opcode 000, sub-code 1000 sets dout_mode to 0 and 1001 sets it to 1. dout_mode is 0 after reset. Sub-code 000x changes nothing.
- R9: Staging contents survive shutdown. Any command that updates a channel's DAC register clears that channel's shutdown flag.
- R10: While pd_allow is low, both shutdown flag outputs read 0 in the same cycle, with no clock edge needed, and shutdown requests are ignored. Raising pd_allow again does not restore the shutdown.
- R11: While clr_n is low at a clock edge:
  - all four code registers become zero;
  - any command in that cycle is discarded;
  - gpo, dout_mode and the shutdown flags keep their values.
- R12: A command with cmd_vld high is visible on the outputs right after the clock edge that samples it. A word with cmd_vld low has no effect.
- R13: With rst_n low at a clock edge, all codes, both shutdown flags, gpo and dout_mode become 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| clr_n | input | 1 | Active-low clear of the code registers |
| pd_allow | input | 1 | Shutdown permitted when high; falling edge wakes both channels |
| cmd_vld | input | 1 | Command word valid strobe |
| cmd_word | input | 16 | Opcode (15:13) and data (12:0) |
| dac_a | output | 13 | DAC register code, channel A |
| dac_b | output | 13 | DAC register code, channel B |
| sd_a | output | 1 | Channel A shut down (output high-impedance) |
| sd_b | output | 1 | Channel B shut down (output high-impedance) |
| gpo | output | 1 | General-purpose logic output |
| dout_mode | output | 1 | Serial-output edge mode |

## Verification

The timing of each result is as follows:

- Codes, gpo and dout_mode are due one edge after the strobe, clear or reset that causes them.
- A shutdown flag set by a command is also due one edge later.
- A wake through pd_allow is due within the same cycle, with no edge in between.

The bench changes inputs on the falling edge and samples 1 ns later. At that point it compares the registered outputs with a model advanced at the previous rising edge. It compares the shutdown flags with that model masked by the pd_allow value just driven, which catches a late or missing asynchronous wake.

// File: rtl/dac_cmd_pkg.sv
// Package: shared types for the dual DAC command decoder.
// Holds the opcode and sub-code encodings and the per-command action
// record that the decoder hands to the channel and control registers.
package dac_cmd_pkg;

    localparam int unsigned NCH   = 2;   // channel count, fixed by the encoding
    localparam int unsigned OP_W  = 3;   // opcode field width
    localparam int unsigned SUB_W = 3;   // sub-code selector width (mode bit separate)

    typedef enum logic [OP_W-1:0] {
        OP_SUB      = 3'b000,
        OP_LDA      = 3'b001,
        OP_LDA_UPD  = 3'b010,
        OP_LD_ALL   = 3'b011,
        OP_UPD_ALL  = 3'b100,
        OP_LDB      = 3'b101,
        OP_LDB_UPD  = 3'b110,
        OP_SD_ALL   = 3'b111
    } op_e;

    typedef enum logic [SUB_W-1:0] {
        SUB_NOP    = 3'b000,
        SUB_UPD_A  = 3'b001,
        SUB_GPO_LO = 3'b010,
        SUB_GPO_HI = 3'b011,
        SUB_MODE   = 3'b100,
        SUB_UPD_B  = 3'b101,
        SUB_SD_A   = 3'b110,
        SUB_SD_B   = 3'b111
    } sub_e;

    typedef struct packed {
        logic [NCH-1:0] ld_in;    // write command data into staging register
        logic [NCH-1:0] upd;      // update DAC register
        logic [NCH-1:0] sd_req;   // request shutdown
        logic           gpo_wr;
        logic           gpo_val;
        logic           mode_wr;
        logic           mode_val;
    } act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
// Module: dac_cmd_decode
// Turns one command word into a set of per-channel actions.
// Assumes the caller has already gated vld with the clear input; with vld
// low every action is inactive. Purely combinational.
module dac_cmd_decode
    import dac_cmd_pkg::*;
#(
    parameter int unsigned CODE_W = 13
) (
    input  logic                     vld,
    input  logic [CODE_W+OP_W-1:0]   word,
    output act_t                     act
);

    localparam int unsigned WORD_W = CODE_W + OP_W;
    localparam int unsigned SUB_HI = CODE_W - 1;
    localparam int unsigned MODE_B = CODE_W - 1 - SUB_W;

    op_e  op;
    sub_e sub;

    // Field extraction.
    always_comb begin
        op  = op_e'(word[WORD_W-1 -: OP_W]);
        sub = sub_e'(word[SUB_HI -: SUB_W]);
    end

    // Opcode and sub-code decode into the action record.
    always_comb begin
        act = '0;
        if (vld) begin
            case (op)
                OP_LDA:     act.ld_in[0] = 1'b1;
                OP_LDB:     act.ld_in[1] = 1'b1;
                OP_LDA_UPD: begin act.ld_in[0] = 1'b1; act.upd = '1; end
                OP_LDB_UPD: begin act.ld_in[1] = 1'b1; act.upd = '1; end
                OP_LD_ALL:  begin act.ld_in = '1;      act.upd = '1; end
                OP_UPD_ALL: act.upd    = '1;
                OP_SD_ALL:  act.sd_req = '1;
                OP_SUB: begin
                    case (sub)
                        SUB_NOP:    ;
                        SUB_UPD_A:  act.upd[0]    = 1'b1;
                        SUB_UPD_B:  act.upd[1]    = 1'b1;
                        SUB_GPO_LO: begin act.gpo_wr = 1'b1; act.gpo_val = 1'b0; end
                        SUB_GPO_HI: begin act.gpo_wr = 1'b1; act.gpo_val = 1'b1; end
                        SUB_MODE:   begin act.mode_wr = 1'b1; act.mode_val = word[MODE_B]; end
                        SUB_SD_A:   act.sd_req[0] = 1'b1;
                        SUB_SD_B:   act.sd_req[1] = 1'b1;
                        default:    ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Guard: a shutdown request and a DAC update never share one command (R5, R9).
    always_comb begin
        a_r5_sd_upd_exclusive: assert (!((|act.sd_req) && (|act.upd)));
    end

    // Guard: extended sub-commands never write a staging register (R6).
    always_comb begin
        if (vld && op == OP_SUB) begin
            a_r6_sub_no_load: assert (act.ld_in == '0);
        end
    end

endmodule

// File: rtl/dac_chan_regs.sv
// Module: dac_chan_regs
// One double-buffered channel: staging register, DAC register and the
// shutdown flag. Assumes clr and the action inputs never arrive together
// (the top discards commands during clear). The reported shutdown flag is
// masked by pd_allow so that a lockout wakes the channel without a clock edge.
module dac_chan_regs #(
    parameter int unsigned CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pd_allow,
    input  logic              ld_in,
    input  logic              upd,
    input  logic              sd_req,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] dac_q,
    output logic              sd_o
);

    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] dac_src;
    logic              sd_q;

    // Staging register: cleared by reset or clear, written by load commands.
    always_ff @(posedge clk) begin
        if (!rst_n)     in_q <= '0;
        else if (clr)   in_q <= '0;
        else if (ld_in) in_q <= data;
    end

    // Source of a DAC update: fresh data when staging is written in the same command.
    always_comb begin
        dac_src = ld_in ? data : in_q;
    end

    // DAC register: cleared by reset or clear, loaded on update.
    always_ff @(posedge clk) begin
        if (!rst_n)   dac_q <= '0;
        else if (clr) dac_q <= '0;
        else if (upd) dac_q <= dac_src;
    end

    // Shutdown state: dropped by lockout or by an update, set by a permitted request.
    always_ff @(posedge clk) begin
        if (!rst_n)         sd_q <= 1'b0;
        else if (!pd_allow) sd_q <= 1'b0;
        else if (upd)       sd_q <= 1'b0;
        else if (sd_req)    sd_q <= 1'b1;
    end

    // Reported flag: lockout low forces wake at once.
    always_comb begin
        sd_o = sd_q & pd_allow;
    end

    // R11: clear empties both registers.
    a_r11_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dac_q == '0 && in_q == '0));

    // R9: any DAC update leaves the channel awake.
    a_r9_upd_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !sd_q);

    // R9: staging contents persist unless loaded or cleared.
    a_r9_stage_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_in && !clr) |=> $stable(in_q));

    // R12: DAC code holds without an update or clear.
    a_r12_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(dac_q));

    // R10: no shutdown survives a cycle with lockout low.
    a_r10_locked_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_allow |=> !sd_q);

endmodule

// File: rtl/dac_ctrl_bits.sv
// Module: dac_ctrl_bits
// Holds the general-purpose logic output and the serial-output mode bit.
// Only power-on reset restores them; clear does not reach this module.
module dac_ctrl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic gpo_wr,
    input  logic gpo_val,
    input  logic mode_wr,
    input  logic mode_val,
    output logic gpo,
    output logic dout_mode
);

    // Logic output register, low after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      gpo <= 1'b0;
        else if (gpo_wr) gpo <= gpo_val;
    end

    // Serial-output mode register, mode 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_mode <= 1'b0;
        else if (mode_wr) dout_mode <= mode_val;
    end

endmodule

// File: rtl/dual_dac_ctrl.sv
// Module: dual_dac_ctrl (top)
// Decodes committed command words and keeps the state of two
// double-buffered DAC channels plus two control bits. Assumes cmd_word is
// stable while cmd_vld is high; a clear discards any same-cycle command.
module dual_dac_ctrl #(
    parameter int unsigned CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              pd_allow,
    input  logic              cmd_vld,
    input  logic [CODE_W+2:0] cmd_word,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b,
    output logic              sd_a,
    output logic              sd_b,
    output logic              gpo,
    output logic              dout_mode
);
    import dac_cmd_pkg::*;

    logic                  clr;
    logic                  vld_eff;
    act_t                  act;
    logic [CODE_W-1:0]     dac_q [NCH];
    logic [NCH-1:0]        sd_v;

    // Clear takes priority: it suppresses the strobe.
    always_comb begin
        clr     = ~clr_n;
        vld_eff = cmd_vld & clr_n;
    end

    dac_cmd_decode #(.CODE_W(CODE_W)) u_dec (
        .vld  (vld_eff),
        .word (cmd_word),
        .act  (act)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dac_chan_regs #(.CODE_W(CODE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .pd_allow (pd_allow),
            .ld_in    (act.ld_in[ch]),
            .upd      (act.upd[ch]),
            .sd_req   (act.sd_req[ch]),
            .data     (cmd_word[CODE_W-1:0]),
            .dac_q    (dac_q[ch]),
            .sd_o     (sd_v[ch])
        );
    end

    dac_ctrl_bits u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpo_wr    (act.gpo_wr),
        .gpo_val   (act.gpo_val),
        .mode_wr   (act.mode_wr),
        .mode_val  (act.mode_val),
        .gpo       (gpo),
        .dout_mode (dout_mode)
    );

    // Output mapping: index 0 is channel A.
    always_comb begin
        dac_a = dac_q[0];
        dac_b = dac_q[1];
        sd_a  = sd_v[0];
        sd_b  = sd_v[1];
    end

    // R7 / R12: logic output moves only on an accepted command.
    a_r7_gpo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_vld || !clr_n) |=> $stable(gpo));

    // R11: clear leaves the control bits alone.
    a_r11_clr_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> ($stable(gpo) && $stable(dout_mode)));

    // R11: clear does not wake a channel that stays locked-in.
    a_r11_clr_keeps_sd: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && pd_allow && sd_a) |=> (sd_a || !pd_allow));

    // R12: codes hold with no strobe and no clear.
    a_r12_codes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_vld && clr_n) |=> ($stable(dac_a) && $stable(dac_b)));

endmodule

// File: tb/dual_dac_ctrl_tb.sv
// Bench for dual_dac_ctrl: directed corner cases, then seeded random traffic,
// all compared against a behavioural model written from the requirements.
module dual_dac_ctrl_tb;

    localparam int CW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_n = 1'b1;
    logic          pd_allow = 1'b1;
    logic          cmd_vld = 1'b0;
    logic [CW+2:0] cmd_word = '0;
    logic [CW-1:0] dac_a, dac_b;
    logic          sd_a, sd_b, gpo, dout_mode;

    always #10 clk = ~clk;   // 50 MHz

    dual_dac_ctrl #(.CODE_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .pd_allow(pd_allow),
        .cmd_vld(cmd_vld), .cmd_word(cmd_word),
        .dac_a(dac_a), .dac_b(dac_b), .sd_a(sd_a), .sd_b(sd_b),
        .gpo(gpo), .dout_mode(dout_mode)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string pend  = "R13";

    logic [CW-1:0] m_in  [2];
    logic [CW-1:0] m_dac [2];
    logic          m_sd  [2];
    logic          m_gpo, m_mode;

    function automatic logic [15:0] opw(input logic [2:0] op, input logic [12:0] d);
        return {op, d};
    endfunction

    function automatic logic [15:0] subw(input logic [3:0] s);
        return {3'b000, s, 9'h000};
    endfunction

    function automatic void m_reset();
        for (int c = 0; c < 2; c++) begin
            m_in[c] = '0; m_dac[c] = '0; m_sd[c] = 1'b0;
        end
        m_gpo = 1'b0; m_mode = 1'b0;
    endfunction

    // Model of one rising edge with the given inputs.
    function automatic void m_step(input bit vld, input logic [15:0] w,
                                   input bit clr, input bit pd);
        logic [1:0] ldi, up, sdr;
        logic [2:0] op;
        logic [3:0] sub;
        ldi = '0; up = '0; sdr = '0;
        op  = w[15:13];
        sub = w[12:9];
        if (clr) begin
            for (int c = 0; c < 2; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        end else if (vld) begin
            case (op)
                3'd1: ldi[0] = 1;
                3'd5: ldi[1] = 1;
                3'd2: begin ldi[0] = 1; up = 2'b11; end
                3'd6: begin ldi[1] = 1; up = 2'b11; end
                3'd3: begin ldi = 2'b11; up = 2'b11; end
                3'd4: up = 2'b11;
                3'd7: sdr = 2'b11;
                default: begin
                    case (sub[3:1])
                        3'd1: up[0] = 1;
                        3'd5: up[1] = 1;
                        3'd2: m_gpo = 1'b0;
                        3'd3: m_gpo = 1'b1;
                        3'd4: m_mode = sub[0];
                        3'd6: sdr[0] = 1;
                        3'd7: sdr[1] = 1;
                        default: ;
                    endcase
                end
            endcase
        end
        for (int c = 0; c < 2; c++) begin
            if (up[c])  m_dac[c] = ldi[c] ? w[12:0] : m_in[c];
            if (ldi[c]) m_in[c]  = w[12:0];
            if (!pd)         m_sd[c] = 1'b0;
            else if (up[c])  m_sd[c] = 1'b0;
            else if (sdr[c]) m_sd[c] = 1'b1;
        end
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "dac_a", 32'(dac_a), 32'(m_dac[0]));
        check(tag, "dac_b", 32'(dac_b), 32'(m_dac[1]));
        check(tag, "sd_a",  32'(sd_a),  32'(m_sd[0] & pd_allow));
        check(tag, "sd_b",  32'(sd_b),  32'(m_sd[1] & pd_allow));
        check(tag, "gpo",   32'(gpo),   32'(m_gpo));
        check(tag, "mode",  32'(dout_mode), 32'(m_mode));
    endtask

    // Drive at the falling edge, check the previous edge's result, advance model.
    task automatic step(input bit vld, input logic [15:0] w, input bit clr,
                        input bit pd, input string tag);
        @(negedge clk);
        cmd_vld = vld; cmd_word = w; clr_n = ~clr; pd_allow = pd;
        #1;
        check_all(pend);
        m_step(vld, w, clr, pd);
        pend = tag;
    endtask

    task automatic cmd(input logic [15:0] w, input string tag);
        step(1'b1, w, 1'b0, pd_allow, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0, 1'b0, pd_allow, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_vld = 1'b0; clr_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        pend = "R13";
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        m_reset();
        do_reset();
        // R13 reset state
        idle("R13");
        check("R13", "dac_a", 32'(dac_a), 32'h0);
        check("R13", "gpo",   32'(gpo),   32'h0);
        check("R13", "mode",  32'(dout_mode), 32'h0);

        // R1 staging only
        cmd(opw(3'b001, 13'h1ABC), "R1");
        cmd(opw(3'b101, 13'h0123), "R1");
        idle("R1");
        check("R1", "dac_a", 32'(dac_a), 32'h0);
        check("R1", "dac_b", 32'(dac_b), 32'h0);
        // R4 copy both
        cmd(opw(3'b100, 13'h0), "R4");
        idle("R4");
        check("R4", "dac_a", 32'(dac_a), 32'h1ABC);
        check("R4", "dac_b", 32'(dac_b), 32'h0123);
        // R2 load-and-update
        cmd(opw(3'b010, 13'h0555), "R2");
        idle("R2");
        check("R2", "dac_a", 32'(dac_a), 32'h0555);
        check("R2", "dac_b", 32'(dac_b), 32'h0123);
        cmd(opw(3'b101, 13'h0777), "R1");
        cmd(opw(3'b110, 13'h0999), "R2");
        idle("R2");
        check("R2", "dac_b", 32'(dac_b), 32'h0999);
        check("R2", "dac_a", 32'(dac_a), 32'h0555);
        // R3 load all
        cmd(opw(3'b011, 13'h1FFF), "R3");
        cmd(opw(3'b001, 13'h0001), "R3");
        cmd(opw(3'b100, 13'h0), "R3");
        idle("R3");
        check("R3", "dac_a", 32'(dac_a), 32'h0001);
        check("R3", "dac_b", 32'(dac_b), 32'h1FFF);
        // R7 logic output
        cmd(subw(4'b0110), "R7");
        idle("R7");
        check("R7", "gpo", 32'(gpo), 32'h1);
        cmd(subw(4'b0100), "R7");
        idle("R7");
        check("R7", "gpo", 32'(gpo), 32'h0);
        // R8 mode and nop
        cmd(subw(4'b1001), "R8");
        idle("R8");
        check("R8", "mode", 32'(dout_mode), 32'h1);
        cmd(subw(4'b0001), "R8");
        idle("R8");
        check("R8", "nop mode", 32'(dout_mode), 32'h1);
        check("R8", "nop dac_b", 32'(dac_b), 32'h1FFF);
        cmd(subw(4'b1000), "R8");
        idle("R8");
        check("R8", "mode", 32'(dout_mode), 32'h0);
        // R5 shutdown both, R9 retention and wake
        cmd(opw(3'b111, 13'h0), "R5");
        idle("R5");
        check("R5", "sd_a", 32'(sd_a), 32'h1);
        check("R5", "sd_b", 32'(sd_b), 32'h1);
        cmd(opw(3'b001, 13'h0AAA), "R9");
        idle("R9");
        check("R9", "sd_a held", 32'(sd_a), 32'h1);
        check("R9", "dac_a held", 32'(dac_a), 32'h0001);
        cmd(subw(4'b0010), "R6");
        idle("R6");
        check("R6", "dac_a", 32'(dac_a), 32'h0AAA);
        check("R9", "sd_a woke", 32'(sd_a), 32'h0);
        check("R6", "sd_b untouched", 32'(sd_b), 32'h1);
        cmd(subw(4'b1100), "R5");
        idle("R5");
        check("R5", "sd_a single", 32'(sd_a), 32'h1);
        cmd(subw(4'b1010), "R6");
        idle("R6");
        check("R6", "dac_b", 32'(dac_b), 32'h1FFF);
        check("R9", "sd_b woke", 32'(sd_b), 32'h0);
        check("R6", "sd_a untouched", 32'(sd_a), 32'h1);
        // R10 lockout
        cmd(opw(3'b111, 13'h0), "R5");
        idle("R5");
        step(1'b0, 16'h0, 1'b0, 1'b0, "R10");
        check("R10", "sd_a immediate", 32'(sd_a), 32'h0);
        check("R10", "sd_b immediate", 32'(sd_b), 32'h0);
        cmd(opw(3'b111, 13'h0), "R10");
        cmd(subw(4'b1110), "R10");
        step(1'b0, 16'h0, 1'b0, 1'b1, "R10");
        idle("R10");
        check("R10", "sd_a after raise", 32'(sd_a), 32'h0);
        check("R10", "sd_b after raise", 32'(sd_b), 32'h0);
        // R11 clear with same-cycle command
        cmd(subw(4'b0110), "R7");
        cmd(subw(4'b1001), "R8");
        cmd(subw(4'b1100), "R5");
        step(1'b1, opw(3'b011, 13'h1234), 1'b1, 1'b1, "R11");
        idle("R11");
        check("R11", "dac_a", 32'(dac_a), 32'h0);
        check("R11", "dac_b", 32'(dac_b), 32'h0);
        check("R11", "gpo kept", 32'(gpo), 32'h1);
        check("R11", "mode kept", 32'(dout_mode), 32'h1);
        check("R11", "sd_a kept", 32'(sd_a), 32'h1);
        cmd(opw(3'b100, 13'h0), "R11");
        idle("R11");
        check("R11", "staging cleared", 32'(dac_b), 32'h0);
        // R12 strobe low ignored
        step(1'b0, opw(3'b011, 13'h0F0F), 1'b0, 1'b1, "R12");
        idle("R12");
        check("R12", "no strobe", 32'(dac_a), 32'h0);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] op;
            logic [12:0] d;
            bit v, c, p;
            op = 3'($urandom % 8);
            d  = 13'($urandom);
            v  = ($urandom % 4) != 0;
            c  = ($urandom % 40) == 0;
            p  = (($urandom % 20) == 0) ? ~pd_allow : pd_allow;
            step(v, {op, d}, c, p, "R12");
        end
        step(1'b0, 16'h0, 1'b0, 1'b1, "R12");
        cmd(subw(4'b0110), "R7");
        idle("R7");

        // R13 second reset with state set
        do_reset();
        idle("R13");
        check("R13", "gpo", 32'(gpo), 32'h0);
        check("R13", "sd_a", 32'(sd_a), 32'h0);
        finish_run();
    end

endmodule